// File: doc/BRIEF.md
# System Register Access Permission Arbiter

This block decides, in the same cycle a request arrives, what happens to a read or write of the translation-control mask register. The request carries a five-field register encoding, the current privilege level (0 to 3), a read/write direction and a set of permission inputs. These inputs describe: whether the feature exists, whether levels 2 and 3 are present or active, the level-3 gate and undefined-priority bits, the fine-grained trap controls, the extended-control gate, a 3-bit nested-virtualization control and the host-mode flag. The block walks an ordered chain of checks and picks exactly one outcome. The six outcomes are undefined, trap to level 2, trap to level 3, redirect to a memory slot, access of the level-1 mask register and access of the level-2 mask register.

Two encodings are decoded. The primary form has group 2'b11, sub1 3'b000, major 4'b0010, minor 4'b0111 and sub2 3'b010. The alias form is identical except that sub1 is 3'b101. The chain of checks differs by encoding, by level and by nested-virtualization mode. Read and write use the same chain except for two points. A write samples its own fine-grain bit, and a write is undefined when the mask it would replace is nonzero. Register storage lies outside this block. The result feeds the exception and register-file logic directly.

Top module: `sra_arbiter`

## Requirements
- R1: An encoding that matches neither form drives noMatch=1, outHot=0, tgtCode=0, excClass=0 and slotOfs=0. A matching encoding drives noMatch=0.
- R2: For a matching encoding, exactly one bit of outHot is set, and its index equals tgtCode. The codes are: 0 undefined, 1 trap to level 2, 2 trap to level 3, 3 redirect, 4 level-1 mask access, 5 level-2 mask access.
- R3: When the feature is absent, or the level is 0, the outcome is undefined (code 0) before any other check.
- R4: With the primary form at level 1, the checks run in this order. First, level 3 present with undefined-priority set and the gate clear gives undefined. Next, the fine-grained trap fires when level 2 is active, the fine-grain feature is present, and either level 3 is present with its fine enable clear or the direction's allow bit (read or write) is 0; this gives code 1. Next, level 2 active with the extended control inactive or its gate clear gives code 1.
- R5: Next in the level-1 primary chain, level 3 present with its gate clear gives code 2, or code 0 when the undefined-instead-of-trap input is set.
- R6: Next, nested-virtualization control 3'b111 gives a redirect (code 3) with slotOfs=12'h330. Every other outcome drives slotOfs=0.
- R7: Last in the level-1 primary chain, a write with the level-1 mask nonzero gives undefined. A read, or a write with a zero mask, gives code 4.
- R8: With the primary form at level 2, only the level-3 checks of R4 and R5 apply. The fine-grained and extended-control inputs have no effect. After those checks, host mode selects code 5, or code 0 for a write with the level-2 mask nonzero. Without host mode the outcome is code 4.
- R9: With the primary form at level 3, the outcome is always code 4.
- R10: With the alias form at level 1, control 3'b101 gives a redirect (code 3). Otherwise, control bit 0 set gives code 1. Otherwise, the outcome is undefined.
- R11: With the alias form at level 2, host mode applies the level-3 checks of R4 and R5 and then gives code 4; without host mode the outcome is undefined. At level 3, host mode gives code 4, otherwise undefined.
- R12: Both traps carry excClass=6'h18. Every other outcome drives excClass=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| encGroup | input | 2 | Encoding field, group |
| encSub1 | input | 3 | Encoding field, first sub-selector (selects primary or alias) |
| encMajor | input | 4 | Encoding field, major |
| encMinor | input | 4 | Encoding field, minor |
| encSub2 | input | 3 | Encoding field, second sub-selector |
| curLevel | input | 2 | Current privilege level 0..3 |
| isWrite | input | 1 | 1 = write, 0 = read |
| featPresent | input | 1 | Mask feature implemented |
| el3Present | input | 1 | Level 3 implemented |
| el3UndefPrio | input | 1 | Level-3 gate failure is undefined at top priority |
| el3UndefInst | input | 1 | Level-3 gate failure is undefined rather than a trap |
| el3Gate | input | 1 | Level-3 enable for mask register access |
| el3FineEn | input | 1 | Level-3 enable of the second fine-grained trap set |
| fineGrainPresent | input | 1 | Second fine-grained trap set implemented |
| fineRdAllow | input | 1 | Fine-grained read allow (0 traps) |
| fineWrAllow | input | 1 | Fine-grained write allow (0 traps) |
| el2Active | input | 1 | Level 2 enabled in the current security state |
| extCtlActive | input | 1 | Level-2 extended control register enabled |
| extCtlGate | input | 1 | Level-2 extended control gate for mask access |
| nvCtl | input | 3 | Nested-virtualization control |
| hostMode | input | 1 | Level 2 runs in host mode |
| mask1Nonzero | input | 1 | Effective level-1 mask is nonzero |
| mask2Nonzero | input | 1 | Effective level-2 mask is nonzero |
| outHot | output | 6 | One-hot outcome, bit index = code |
| tgtCode | output | 3 | Encoded outcome |
| excClass | output | 6 | Exception class for traps |
| slotOfs | output | 12 | Memory slot offset on redirect |
| noMatch | output | 1 | Encoding matches neither form |

## Verification
The level-1 primary chain is walked exhaustively over every combination of its level-3, fine-grain, extended-control, nested-virtualization, direction and mask-nonzero inputs. This shows that each check wins only when every earlier check is clear, and that the read and write allow bits are not swapped. Directed cases on the alias form separate control 3'b101 from other values with bit 0 set, and both from values with bit 0 clear. Directed cases at levels 2 and 3 show that host mode alone picks between the two mask registers and that the inputs used only at level 1 have no effect. A random sweep over both encodings, near-miss encodings and all levels finds outcomes that leak across level or encoding boundaries.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int OUT_N  = 6;
  localparam int CODE_W = $clog2(OUT_N);

  localparam logic [1:0] ENC_GROUP = 2'b11;
  localparam logic [2:0] ENC_SUB1_PRIM = 3'b000;
  localparam logic [2:0] ENC_SUB1_ALIAS = 3'b101;
  localparam logic [3:0] ENC_MAJOR = 4'b0010;
  localparam logic [3:0] ENC_MINOR = 4'b0111;
  localparam logic [2:0] ENC_SUB2 = 3'b010;

  // outcome codes; the one-hot bit index equals the code
  localparam int OC_UNDEF = 0;
  localparam int OC_TRAP2 = 1;
  localparam int OC_TRAP3 = 2;
  localparam int OC_REDIR = 3;
  localparam int OC_ACC1  = 4;
  localparam int OC_ACC2  = 5;

  // strobes from control to datapath, exactly one set when matched
  typedef struct packed {
    logic noMatch;
    logic acc2;
    logic acc1;
    logic redir;
    logic trap3;
    logic trap2;
    logic undef;
  } strobe_t;
endpackage

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
(
  input  logic [1:0] encGroup,
  input  logic [2:0] encSub1,
  input  logic [3:0] encMajor,
  input  logic [3:0] encMinor,
  input  logic [2:0] encSub2,
  input  logic [1:0] curLevel,
  input  logic       isWrite,
  input  logic       featPresent,
  input  logic       el3Present,
  input  logic       el3UndefPrio,
  input  logic       el3UndefInst,
  input  logic       el3Gate,
  input  logic       el3FineEn,
  input  logic       fineGrainPresent,
  input  logic       fineRdAllow,
  input  logic       fineWrAllow,
  input  logic       el2Active,
  input  logic       extCtlActive,
  input  logic       extCtlGate,
  input  logic [2:0] nvCtl,
  input  logic       hostMode,
  input  logic       mask1Nonzero,
  input  logic       mask2Nonzero,
  output strobe_t    strobes
);
  logic commonHit, isPrim, isAlias;
  logic undefFirst, el3Blocked, fineBit, fineTrap, extTrap;

  assign commonHit  = (encGroup == ENC_GROUP) && (encMajor == ENC_MAJOR) &&
                      (encMinor == ENC_MINOR) && (encSub2 == ENC_SUB2);
  assign isPrim     = commonHit && (encSub1 == ENC_SUB1_PRIM);
  assign isAlias    = commonHit && (encSub1 == ENC_SUB1_ALIAS);
  assign undefFirst = el3Present && el3UndefPrio && !el3Gate;
  assign el3Blocked = el3Present && !el3Gate;
  assign fineBit    = isWrite ? fineWrAllow : fineRdAllow;
  assign fineTrap   = el2Active && fineGrainPresent && ((el3Present && !el3FineEn) || !fineBit);
  assign extTrap    = el2Active && (!extCtlActive || !extCtlGate);

  always_comb begin
    strobes = '0;
    if (!isPrim && !isAlias) begin
      strobes.noMatch = 1'b1;
    end else if (!featPresent || curLevel == 2'd0) begin
      strobes.undef = 1'b1;
    end else if (isPrim) begin
      case (curLevel)
        2'd1: begin
          if (undefFirst)                   strobes.undef = 1'b1;
          else if (fineTrap || extTrap)     strobes.trap2 = 1'b1;
          else if (el3Blocked) begin
            if (el3UndefInst)               strobes.undef = 1'b1;
            else                            strobes.trap3 = 1'b1;
          end
          else if (nvCtl == 3'b111)         strobes.redir = 1'b1;
          else if (isWrite && mask1Nonzero) strobes.undef = 1'b1;
          else                              strobes.acc1  = 1'b1;
        end
        2'd2: begin
          if (undefFirst)                   strobes.undef = 1'b1;
          else if (el3Blocked) begin
            if (el3UndefInst)               strobes.undef = 1'b1;
            else                            strobes.trap3 = 1'b1;
          end
          else if (hostMode) begin
            if (isWrite && mask2Nonzero)    strobes.undef = 1'b1;
            else                            strobes.acc2  = 1'b1;
          end
          else                              strobes.acc1  = 1'b1;
        end
        default:                            strobes.acc1  = 1'b1;
      endcase
    end else begin
      case (curLevel)
        2'd1: begin
          if (nvCtl == 3'b101)              strobes.redir = 1'b1;
          else if (nvCtl[0])                strobes.trap2 = 1'b1;
          else                              strobes.undef = 1'b1;
        end
        2'd2: begin
          if (!hostMode)                    strobes.undef = 1'b1;
          else if (undefFirst)              strobes.undef = 1'b1;
          else if (el3Blocked) begin
            if (el3UndefInst)               strobes.undef = 1'b1;
            else                            strobes.trap3 = 1'b1;
          end
          else                              strobes.acc1  = 1'b1;
        end
        default: begin
          if (hostMode)                     strobes.acc1  = 1'b1;
          else                              strobes.undef = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sra_dp.sv
module sra_dp
  import sra_pkg::*;
#(
  parameter int          EC_W     = 6,
  parameter logic [EC_W-1:0] EC_TRAP = 6'h18,
  parameter int          OFS_W    = 12,
  parameter logic [OFS_W-1:0] REDIR_OFS = 12'h330
) (
  input  strobe_t           strobes,
  output logic [OUT_N-1:0]  outHot,
  output logic [CODE_W-1:0] tgtCode,
  output logic [EC_W-1:0]   excClass,
  output logic [OFS_W-1:0]  slotOfs,
  output logic              noMatch
);
  logic [CODE_W-1:0] codeTerm [OUT_N];

  assign outHot[OC_UNDEF] = strobes.undef;
  assign outHot[OC_TRAP2] = strobes.trap2;
  assign outHot[OC_TRAP3] = strobes.trap3;
  assign outHot[OC_REDIR] = strobes.redir;
  assign outHot[OC_ACC1]  = strobes.acc1;
  assign outHot[OC_ACC2]  = strobes.acc2;

  genvar g;
  generate
    for (g = 0; g < OUT_N; g++) begin : gEnc
      assign codeTerm[g] = outHot[g] ? CODE_W'(g) : '0;
    end
  endgenerate

  always_comb begin
    tgtCode = '0;
    for (int i = 0; i < OUT_N; i++) tgtCode = tgtCode | codeTerm[i];
  end

  assign excClass = (strobes.trap2 || strobes.trap3) ? EC_TRAP : '0;
  assign slotOfs  = strobes.redir ? REDIR_OFS : '0;
  assign noMatch  = strobes.noMatch;
endmodule

// File: rtl/sra_arbiter.sv
module sra_arbiter
  import sra_pkg::*;
#(
  parameter int EC_W  = 6,
  parameter int OFS_W = 12
) (
  input  logic [1:0]        encGroup,
  input  logic [2:0]        encSub1,
  input  logic [3:0]        encMajor,
  input  logic [3:0]        encMinor,
  input  logic [2:0]        encSub2,
  input  logic [1:0]        curLevel,
  input  logic              isWrite,
  input  logic              featPresent,
  input  logic              el3Present,
  input  logic              el3UndefPrio,
  input  logic              el3UndefInst,
  input  logic              el3Gate,
  input  logic              el3FineEn,
  input  logic              fineGrainPresent,
  input  logic              fineRdAllow,
  input  logic              fineWrAllow,
  input  logic              el2Active,
  input  logic              extCtlActive,
  input  logic              extCtlGate,
  input  logic [2:0]        nvCtl,
  input  logic              hostMode,
  input  logic              mask1Nonzero,
  input  logic              mask2Nonzero,
  output logic [OUT_N-1:0]  outHot,
  output logic [CODE_W-1:0] tgtCode,
  output logic [EC_W-1:0]   excClass,
  output logic [OFS_W-1:0]  slotOfs,
  output logic              noMatch
);
  strobe_t strobes;

  sra_ctrl u_ctrl (
    .encGroup(encGroup), .encSub1(encSub1), .encMajor(encMajor),
    .encMinor(encMinor), .encSub2(encSub2), .curLevel(curLevel),
    .isWrite(isWrite), .featPresent(featPresent), .el3Present(el3Present),
    .el3UndefPrio(el3UndefPrio), .el3UndefInst(el3UndefInst), .el3Gate(el3Gate),
    .el3FineEn(el3FineEn), .fineGrainPresent(fineGrainPresent),
    .fineRdAllow(fineRdAllow), .fineWrAllow(fineWrAllow), .el2Active(el2Active),
    .extCtlActive(extCtlActive), .extCtlGate(extCtlGate), .nvCtl(nvCtl),
    .hostMode(hostMode), .mask1Nonzero(mask1Nonzero), .mask2Nonzero(mask2Nonzero),
    .strobes(strobes)
  );

  sra_dp #(
    .EC_W(EC_W), .EC_TRAP(EC_W'(6'h18)), .OFS_W(OFS_W), .REDIR_OFS(OFS_W'(12'h330))
  ) u_dp (
    .strobes(strobes), .outHot(outHot), .tgtCode(tgtCode),
    .excClass(excClass), .slotOfs(slotOfs), .noMatch(noMatch)
  );
endmodule

// File: rtl/sra_arbiter_chk.sv
module sra_arbiter_chk
  import sra_pkg::*;
#(
  parameter int EC_W  = 6,
  parameter int OFS_W = 12
) (
  input logic [1:0]        curLevel,
  input logic              featPresent,
  input logic [2:0]        encSub1,
  input logic              hostMode,
  input logic [OUT_N-1:0]  outHot,
  input logic [CODE_W-1:0] tgtCode,
  input logic [EC_W-1:0]   excClass,
  input logic [OFS_W-1:0]  slotOfs,
  input logic              noMatch
);
  always_comb begin
    p_nomatch_quiet_r1: assert (!noMatch || (outHot == '0 && excClass == '0 && slotOfs == '0))
      else $error("no-match outcome not quiet");
    p_single_outcome_r2: assert (noMatch || ($countones(outHot) == 1 && outHot[tgtCode]))
      else $error("outcome not one-hot or code mismatch");
    p_absent_undef_r3: assert (noMatch || (featPresent && curLevel != 2'd0) || outHot[OC_UNDEF])
      else $error("absent feature or level 0 not undefined");
    p_redir_offset_r6: assert (outHot[OC_REDIR] == (slotOfs != '0))
      else $error("slot offset disagrees with redirect");
    p_level3_prim_r9: assert (noMatch || !featPresent || curLevel != 2'd3 ||
                              encSub1 != ENC_SUB1_PRIM || outHot[OC_ACC1])
      else $error("level 3 primary not level-1 access");
    p_alias_nohost_r11: assert (noMatch || !featPresent || curLevel < 2'd2 ||
                                encSub1 != ENC_SUB1_ALIAS || hostMode || outHot[OC_UNDEF])
      else $error("alias without host mode not undefined");
    p_trap_class_r12: assert ((outHot[OC_TRAP2] || outHot[OC_TRAP3]) == (excClass != '0))
      else $error("exception class disagrees with trap");
  end
endmodule

bind sra_arbiter sra_arbiter_chk #(.EC_W(EC_W), .OFS_W(OFS_W)) u_chk (
  .curLevel(curLevel), .featPresent(featPresent), .encSub1(encSub1),
  .hostMode(hostMode), .outHot(outHot), .tgtCode(tgtCode), .excClass(excClass),
  .slotOfs(slotOfs), .noMatch(noMatch)
);

// File: tb/sra_arbiter_bench.sv
`timescale 1ns/1ps
module sra_arbiter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0] grp; logic [2:0] s1; logic [3:0] maj; logic [3:0] mnr; logic [2:0] s2;
    logic [1:0] lvl; logic wr; logic feat; logic e3p; logic prio; logic uinst; logic gate;
    logic fen; logic fgp; logic frd; logic fwr; logic e2a; logic xact; logic xgate;
    logic [2:0] nv; logic host; logic nz1; logic nz2;
  } stim_t;

  typedef struct {
    logic [2:0] code;
    logic       nm;
    string      tag;
  } exp_t;

  stim_t cur;
  exp_t  expQ[$];
  int    nRun = 0;
  int    nFail = 0;
  bit    done = 0;

  logic [5:0]  outHot;
  logic [2:0]  tgtCode;
  logic [5:0]  excClass;
  logic [11:0] slotOfs;
  logic        noMatch;

  sra_arbiter u_sra_arbiter (
    .encGroup(cur.grp), .encSub1(cur.s1), .encMajor(cur.maj), .encMinor(cur.mnr),
    .encSub2(cur.s2), .curLevel(cur.lvl), .isWrite(cur.wr), .featPresent(cur.feat),
    .el3Present(cur.e3p), .el3UndefPrio(cur.prio), .el3UndefInst(cur.uinst),
    .el3Gate(cur.gate), .el3FineEn(cur.fen), .fineGrainPresent(cur.fgp),
    .fineRdAllow(cur.frd), .fineWrAllow(cur.fwr), .el2Active(cur.e2a),
    .extCtlActive(cur.xact), .extCtlGate(cur.xgate), .nvCtl(cur.nv),
    .hostMode(cur.host), .mask1Nonzero(cur.nz1), .mask2Nonzero(cur.nz2),
    .outHot(outHot), .tgtCode(tgtCode), .excClass(excClass), .slotOfs(slotOfs),
    .noMatch(noMatch)
  );

  // reference decision from the requirements
  function automatic exp_t model(input stim_t s);
    exp_t e;
    logic prim, alias_, ufirst, blk, fbit;
    prim   = s.grp == 2'b11 && s.s1 == 3'b000 && s.maj == 4'b0010 && s.mnr == 4'b0111 && s.s2 == 3'b010;
    alias_ = s.grp == 2'b11 && s.s1 == 3'b101 && s.maj == 4'b0010 && s.mnr == 4'b0111 && s.s2 == 3'b010;
    ufirst = s.e3p && s.prio && !s.gate;
    blk    = s.e3p && !s.gate;
    fbit   = s.wr ? s.fwr : s.frd;
    e.nm = 1'b0; e.code = 3'd0; e.tag = "R1";
    if (!prim && !alias_) begin e.nm = 1'b1; e.tag = "R1"; end
    else if (!s.feat || s.lvl == 2'd0) begin e.code = 3'd0; e.tag = "R3"; end
    else if (prim && s.lvl == 2'd1) begin
      if (ufirst) begin e.code = 3'd0; e.tag = "R4"; end
      else if (s.e2a && s.fgp && ((s.e3p && !s.fen) || !fbit)) begin e.code = 3'd1; e.tag = "R4"; end
      else if (s.e2a && (!s.xact || !s.xgate)) begin e.code = 3'd1; e.tag = "R4"; end
      else if (blk) begin e.code = s.uinst ? 3'd0 : 3'd2; e.tag = "R5"; end
      else if (s.nv == 3'b111) begin e.code = 3'd3; e.tag = "R6"; end
      else begin e.code = (s.wr && s.nz1) ? 3'd0 : 3'd4; e.tag = "R7"; end
    end
    else if (prim && s.lvl == 2'd2) begin
      e.tag = "R8";
      if (ufirst) e.code = 3'd0;
      else if (blk) e.code = s.uinst ? 3'd0 : 3'd2;
      else if (s.host) e.code = (s.wr && s.nz2) ? 3'd0 : 3'd5;
      else e.code = 3'd4;
    end
    else if (prim) begin e.code = 3'd4; e.tag = "R9"; end
    else if (s.lvl == 2'd1) begin
      e.tag = "R10";
      if (s.nv == 3'b101) e.code = 3'd3;
      else if (s.nv[0]) e.code = 3'd1;
      else e.code = 3'd0;
    end
    else begin
      e.tag = "R11";
      if (!s.host) e.code = 3'd0;
      else if (s.lvl == 2'd3) e.code = 3'd4;
      else if (ufirst) e.code = 3'd0;
      else if (blk) e.code = s.uinst ? 3'd0 : 3'd2;
      else e.code = 3'd4;
    end
    return e;
  endfunction

  task automatic send(input stim_t s);
    @(posedge clk);
    cur = s;
    expQ.push_back(model(s));
  endtask

  function automatic stim_t base(input logic alias_, input logic [1:0] lvl);
    stim_t s = '0;
    s.grp = 2'b11; s.s1 = alias_ ? 3'b101 : 3'b000; s.maj = 4'b0010;
    s.mnr = 4'b0111; s.s2 = 3'b010; s.lvl = lvl; s.feat = 1'b1;
    s.gate = 1'b1; s.fen = 1'b1; s.frd = 1'b1; s.fwr = 1'b1;
    s.xact = 1'b1; s.xgate = 1'b1;
    return s;
  endfunction

  // monitor: pop and compare away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        logic [5:0] hotExp;
        logic [5:0] ecExp;
        logic [11:0] ofsExp;
        logic [2:0] codeExp;
        e = expQ.pop_front();
        codeExp = e.nm ? 3'd0 : e.code;
        hotExp  = e.nm ? 6'd0 : (6'd1 << e.code);
        ecExp   = (!e.nm && (e.code == 3'd1 || e.code == 3'd2)) ? 6'h18 : 6'h00;
        ofsExp  = (!e.nm && e.code == 3'd3) ? 12'h330 : 12'h000;
        nRun++;
        if (noMatch !== e.nm || tgtCode !== codeExp || outHot !== hotExp ||
            excClass !== ecExp || slotOfs !== ofsExp) begin
          nFail++;
          if (noMatch !== e.nm)
            $display("FAIL R1 noMatch act=%0b exp=%0b", noMatch, e.nm);
          if (tgtCode !== codeExp)
            $display("FAIL %s code act=%0d exp=%0d", e.tag, tgtCode, codeExp);
          if (outHot !== hotExp)
            $display("FAIL R2 hot act=%b exp=%b (%s)", outHot, hotExp, e.tag);
          if (excClass !== ecExp)
            $display("FAIL R12 class act=%h exp=%h (%s)", excClass, ecExp, e.tag);
          if (slotOfs !== ofsExp)
            $display("FAIL R6 offset act=%h exp=%h (%s)", slotOfs, ofsExp, e.tag);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    stim_t s;
    cur = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    send('0);                                   // R1 reset state: no match
    s = base(1'b0, 2'd1); s.s2 = 3'b011; send(s);  // R1 near miss
    s = base(1'b0, 2'd1); s.feat = 1'b0; send(s);  // R3
    s = base(1'b0, 2'd0); send(s);                 // R3
    s = base(1'b0, 2'd1); send(s);                 // R7 plain access
    s = base(1'b0, 2'd1); s.wr = 1'b1; s.nz1 = 1'b1; send(s); // R7 write undef
    s = base(1'b0, 2'd1); s.nz1 = 1'b1; send(s);   // R7 read unaffected
    s = base(1'b0, 2'd1); s.nv = 3'b111; send(s);  // R6
    s = base(1'b0, 2'd1); s.e3p = 1'b1; s.gate = 1'b0; send(s); // R5 trap3
    s.uinst = 1'b1; send(s);                        // R5 undef
    s.prio = 1'b1; s.e2a = 1'b1; s.fgp = 1'b1; s.frd = 1'b0; send(s); // R4 prio first
    s = base(1'b0, 2'd1); s.e2a = 1'b1; s.fgp = 1'b1; s.fwr = 1'b0; send(s); // R4 read ignores write bit
    s.wr = 1'b1; send(s);                           // R4 write bit traps
    s = base(1'b0, 2'd2); s.host = 1'b1; send(s);   // R8 level-2 mask
    s.wr = 1'b1; s.nz2 = 1'b1; send(s);             // R8 write undef
    s = base(1'b0, 2'd2); s.e2a = 1'b1; s.xact = 1'b0; s.fgp = 1'b1; s.frd = 1'b0; send(s); // R8 ignored
    s = base(1'b0, 2'd3); s.e3p = 1'b1; s.gate = 1'b0; send(s); // R9
    for (int v = 0; v < 8; v++) begin               // R10
      s = base(1'b1, 2'd1); s.nv = 3'(v); send(s);
    end
    s = base(1'b1, 2'd2); send(s);                  // R11 no host
    s.host = 1'b1; send(s);                         // R11 host
    s.e3p = 1'b1; s.gate = 1'b0; send(s);           // R11 trap3
    s = base(1'b1, 2'd3); s.host = 1'b1; send(s);   // R11 level 3
    // exhaustive walk of the level-1 primary chain: R4 R5 R6 R7 R12
    for (int k = 0; k < 65536; k++) begin
      logic [15:0] b;
      b = 16'(k);
      s = base(1'b0, 2'd1);
      s.e3p = b[0]; s.prio = b[1]; s.uinst = b[2]; s.gate = b[3]; s.fen = b[4];
      s.fgp = b[5]; s.frd = b[6]; s.fwr = b[7]; s.e2a = b[8]; s.xact = b[9];
      s.xgate = b[10]; s.nv = b[13:11]; s.wr = b[14]; s.nz1 = b[15];
      send(s);
    end
    // random sweep across levels and encodings
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      s = stim_t'({$urandom, $urandom});
      s.feat = (r[3:0] != 4'd0);
      if (r[5:4] != 2'd0) begin
        s.grp = 2'b11; s.maj = 4'b0010; s.mnr = 4'b0111; s.s2 = 3'b010;
        s.s1 = r[6] ? 3'b101 : 3'b000;
        if (r[5:4] == 2'd3 && r[7]) s.s1 = 3'b100;
      end
      send(s);
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule